// File: doc/BRIEF.md
# Bit-Serial Port Transfer Engine

This block owns a bank of 32 transfer registers, each 32 bits wide, and moves bit fields of programmable width between those registers and a set of up to 256 external serial ports. A command names a register, a port number, a direction and a width code. A receive command collects a field from the port and lands it in the most significant end of the register, pushing the old contents down. A send command pushes the least significant bits of the register out to the port and leaves the register shifted down by the same amount.

Each bit crosses the port boundary on one valid/ready beat, least significant bit first, with the selected port number held on a shared select output for the whole transfer. The engine is busy from the cycle after a command is taken until write-back, then pulses done for one cycle. A separate move port gives ordinary single-cycle register writes and registered reads of the bank. Width code zero selects a full 32-bit transfer.

Top module: `xfer_engine`

## Requirements
- R1: After reset busy, done, tx_valid and rx_ready are 0 and every transfer register reads 0 through the move port.
- R2: A command is taken on a rising edge where cmd_valid is 1 and busy is 0; busy is 1 from the next cycle until the done cycle, and cmd_valid raised while busy is ignored (no second done, no register changed).
- R3: Width code 0 moves 32 bits; codes 1 to 31 move exactly that many bits, one per accepted beat.
- R4: A send (cmd_is_out = 1) presents register bit k on tx_data with tx_valid for beat k, k counting up from 0, with port_sel equal to the commanded port; rx_ready stays 0.
- R5: After a send of N bits the register holds its old value shifted right by N with zeros filling the top (0 when N = 32).
- R6: A receive (cmd_is_out = 0) raises rx_ready per beat; the N bits received, first one least significant, form a field v, and the register becomes (old >> N) | (v << (32 - N)).
- R7: done is 1 for exactly one cycle, 7 + N + S rising edges after the accepting edge, where S counts beat cycles in which the port did not complete the handshake; busy is 0 in the done cycle.
- R8: While tx_valid is 1 and tx_ready is 0, tx_valid, tx_data and port_sel hold their values into the next cycle.
- R9: A move-port write takes effect at the rising edge where mv_we is 1; mv_rdata shows the register at mv_addr one edge after the address is applied, and a read of a register under transfer returns its pre-transfer value until the write-back edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_is_out | input | 1 | 1 = send to port, 0 = receive from port |
| cmd_reg | input | 5 | Transfer register index |
| cmd_port | input | 8 | Port number |
| cmd_width | input | 5 | Width code, 0 means 32 bits |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after write-back |
| port_sel | output | 8 | Port number of the current transfer |
| tx_valid | output | 1 | Send bit valid |
| tx_data | output | 1 | Send bit |
| tx_ready | input | 1 | Port accepts the send bit |
| rx_ready | output | 1 | Engine accepts a receive bit |
| rx_valid | input | 1 | Port offers a receive bit |
| rx_data | input | 1 | Receive bit |
| mv_we | input | 1 | Move-port write enable |
| mv_addr | input | 5 | Move-port register index |
| mv_wdata | input | 32 | Move-port write data |
| mv_rdata | output | 32 | Move-port read data, registered |

## Verification
The done pulse is due 7 + N + S edges after the accepting edge, so the bench counts falling edges from that edge, tallies the stall cycles its own port model inserts, and compares the count at the first falling edge that shows done. Each port beat completes on the edge after the bench offers valid or ready at a falling edge, so bits and stalls are recorded at that falling edge. Register results are read through the move port, whose data reflects the bank one edge after the address, so the pre-transfer value is checked every cycle up to and including the done cycle and the new value one cycle later.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  // Transfer sequencing states
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_SETUP = 3'd2,
    ST_SHIFT = 3'd3,
    ST_MERGE = 3'd4,
    ST_WB    = 3'd5
  } xfer_state_e;

endpackage

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
#(
  parameter int OVERHEAD = 7,
  parameter int CNT_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_fire,
  input  logic             beat_fire,
  input  logic [CNT_W-1:0] beats,
  output xfer_state_e      state,
  output logic [CNT_W-1:0] beat_idx,
  output logic             last_beat
);

  // LOAD, MERGE and WB take one cycle each; the rest of the overhead is setup
  localparam int SETUP_CYC = OVERHEAD - 3;
  localparam int SC_W      = $clog2(SETUP_CYC + 1);

  logic [SC_W-1:0] setup_cnt;

  assign last_beat = (beat_idx == (beats - CNT_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      setup_cnt <= '0;
      beat_idx  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmd_fire) state <= ST_LOAD;
        end
        ST_LOAD: begin
          state     <= ST_SETUP;
          setup_cnt <= SC_W'(SETUP_CYC - 1);
        end
        ST_SETUP: begin
          if (setup_cnt == '0) begin
            state    <= ST_SHIFT;
            beat_idx <= '0;
          end else begin
            setup_cnt <= setup_cnt - SC_W'(1);
          end
        end
        ST_SHIFT: begin
          if (beat_fire) begin
            if (last_beat) state <= ST_MERGE;
            else           beat_idx <= beat_idx + CNT_W'(1);
          end
        end
        ST_MERGE: state <= ST_WB;
        ST_WB:    state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xfer_serdes.sv
module xfer_serdes #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shifting,
  input  logic              load,
  input  logic              is_out,
  input  logic [DATA_W-1:0] src_word,
  input  logic [IDX_W-1:0]  bit_pos,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic              rx_data,
  output logic              tx_valid,
  output logic              tx_data,
  output logic              rx_ready,
  output logic              beat_fire,
  output logic [DATA_W-1:0] field
);

  logic tx_beat;
  logic rx_beat;

  assign tx_valid  = shifting & is_out;
  assign rx_ready  = shifting & ~is_out;
  assign tx_data   = tx_valid & src_word[bit_pos];
  assign tx_beat   = tx_valid & tx_ready;
  assign rx_beat   = rx_ready & rx_valid;
  assign beat_fire = tx_beat | rx_beat;

  // Received bits collect at their beat position, first bit at position 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field <= '0;
    end else if (load) begin
      field <= '0;
    end else if (rx_beat) begin
      field[bit_pos] <= rx_data;
    end
  end

endmodule

// File: rtl/xfer_bank.sv
module xfer_bank #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32,
  parameter int REG_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mv_we,
  input  logic [REG_W-1:0]  mv_addr,
  input  logic [DATA_W-1:0] mv_wdata,
  output logic [DATA_W-1:0] mv_rdata,
  input  logic [REG_W-1:0]  ld_addr,
  output logic [DATA_W-1:0] ld_data,
  input  logic              wb_en,
  input  logic [REG_W-1:0]  wb_addr,
  input  logic [DATA_W-1:0] wb_data
);

  logic [DATA_W-1:0] regs [NUM_REGS];

  assign ld_data = regs[ld_addr];

  // Write-back is placed after the move write so it wins on the same index
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      mv_rdata <= '0;
    end else begin
      if (mv_we) regs[mv_addr] <= mv_wdata;
      if (wb_en) regs[wb_addr] <= wb_data;
      mv_rdata <= regs[mv_addr];
    end
  end

endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
  import xfer_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32,
  parameter int PORT_W   = 8,
  parameter int OVERHEAD = 7,
  localparam int REG_W   = $clog2(NUM_REGS),
  localparam int WCODE_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic               cmd_is_out,
  input  logic [REG_W-1:0]   cmd_reg,
  input  logic [PORT_W-1:0]  cmd_port,
  input  logic [WCODE_W-1:0] cmd_width,
  output logic               busy,
  output logic               done,
  output logic [PORT_W-1:0]  port_sel,
  output logic               tx_valid,
  output logic               tx_data,
  input  logic               tx_ready,
  output logic               rx_ready,
  input  logic               rx_valid,
  input  logic               rx_data,
  input  logic               mv_we,
  input  logic [REG_W-1:0]   mv_addr,
  input  logic [DATA_W-1:0]  mv_wdata,
  output logic [DATA_W-1:0]  mv_rdata
);

  localparam int CNT_W = WCODE_W + 1;

  // Send: drop the N low bits that left through the port
  function automatic logic [DATA_W-1:0] f_drain(input logic [DATA_W-1:0] v,
                                                input logic [CNT_W-1:0]  n);
    return v >> n;
  endfunction

  // Receive: old contents move down, the collected field lands on top
  function automatic logic [DATA_W-1:0] f_fill(input logic [DATA_W-1:0] v,
                                               input logic [DATA_W-1:0] fld,
                                               input logic [CNT_W-1:0]  n);
    return (v >> n) | (fld << (CNT_W'(DATA_W) - n));
  endfunction

  xfer_state_e       state;
  logic [CNT_W-1:0]  beat_idx;
  logic              last_beat;
  logic              cmd_fire;
  logic              beat_fire;
  logic              wb_fire;
  logic              cur_out;
  logic [REG_W-1:0]  cur_reg;
  logic [PORT_W-1:0] cur_port;
  logic [CNT_W-1:0]  cur_beats;
  logic [DATA_W-1:0] src_q;
  logic [DATA_W-1:0] res_q;
  logic [DATA_W-1:0] ld_data;
  logic [DATA_W-1:0] field;
  logic              done_q;

  assign cmd_fire = cmd_valid & (state == ST_IDLE);
  assign wb_fire  = (state == ST_WB);
  assign busy     = (state != ST_IDLE);
  assign done     = done_q;
  assign port_sel = cur_port;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_out   <= 1'b0;
      cur_reg   <= '0;
      cur_port  <= '0;
      cur_beats <= '0;
      src_q     <= '0;
      res_q     <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= wb_fire;
      if (cmd_fire) begin
        cur_out   <= cmd_is_out;
        cur_reg   <= cmd_reg;
        cur_port  <= cmd_port;
        cur_beats <= (cmd_width == '0) ? CNT_W'(DATA_W) : CNT_W'(cmd_width);
      end
      if (state == ST_LOAD) src_q <= ld_data;
      if (state == ST_MERGE)
        res_q <= cur_out ? f_drain(src_q, cur_beats)
                         : f_fill(src_q, field, cur_beats);
    end
  end

  xfer_ctrl #(
    .OVERHEAD (OVERHEAD),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_fire  (cmd_fire),
    .beat_fire (beat_fire),
    .beats     (cur_beats),
    .state     (state),
    .beat_idx  (beat_idx),
    .last_beat (last_beat)
  );

  xfer_serdes #(
    .DATA_W (DATA_W),
    .IDX_W  (WCODE_W)
  ) u_serdes (
    .clk       (clk),
    .rst_n     (rst_n),
    .shifting  (state == ST_SHIFT),
    .load      (state == ST_LOAD),
    .is_out    (cur_out),
    .src_word  (src_q),
    .bit_pos   (beat_idx[WCODE_W-1:0]),
    .tx_ready  (tx_ready),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .rx_ready  (rx_ready),
    .beat_fire (beat_fire),
    .field     (field)
  );

  xfer_bank #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .mv_we    (mv_we),
    .mv_addr  (mv_addr),
    .mv_wdata (mv_wdata),
    .mv_rdata (mv_rdata),
    .ld_addr  (cur_reg),
    .ld_data  (ld_data),
    .wb_en    (wb_fire),
    .wb_addr  (cur_reg),
    .wb_data  (res_q)
  );

endmodule

// File: rtl/xfer_engine_chk.sv
module xfer_engine_chk #(
  parameter int PORT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              busy,
  input logic              done,
  input logic [PORT_W-1:0] port_sel,
  input logic              tx_valid,
  input logic              tx_data,
  input logic              tx_ready,
  input logic              rx_ready,
  input logic              beat_fire,
  input logic              wb_fire
);

  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r2_take_command: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> busy);

  a_r2_busy_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(port_sel)));

  a_r4_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && rx_ready));

  a_r3_beats_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire |-> busy);

  a_r7_wb_after_beats: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |-> (busy && !beat_fire && !tx_valid && !rx_ready));

endmodule

bind xfer_engine xfer_engine_chk #(.PORT_W(PORT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .busy      (busy),
  .done      (done),
  .port_sel  (port_sel),
  .tx_valid  (tx_valid),
  .tx_data   (tx_data),
  .tx_ready  (tx_ready),
  .rx_ready  (rx_ready),
  .beat_fire (beat_fire),
  .wb_fire   (wb_fire)
);

// File: tb/test_xfer_engine.sv
`timescale 1ns/1ps
module test_xfer_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_is_out = 1'b0;
  logic [4:0]  cmd_reg = '0, cmd_width = '0;
  logic [7:0]  cmd_port = '0;
  logic        busy, done, tx_valid, tx_data, rx_ready;
  logic [7:0]  port_sel;
  logic        tx_ready = 1'b0, rx_valid = 1'b0, rx_data = 1'b0;
  logic        mv_we = 1'b0;
  logic [4:0]  mv_addr = '0;
  logic [31:0] mv_wdata = '0, mv_rdata;

  int checks = 0;
  int errors = 0;
  logic [31:0] shadow [32];

  always #10 clk = ~clk;  // 50 MHz

  xfer_engine i_xfer_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_out(cmd_is_out),
    .cmd_reg(cmd_reg), .cmd_port(cmd_port), .cmd_width(cmd_width),
    .busy(busy), .done(done), .port_sel(port_sel),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .mv_we(mv_we), .mv_addr(mv_addr), .mv_wdata(mv_wdata), .mv_rdata(mv_rdata)
  );

  function automatic int width_of(input int code);
    return (code == 0) ? 32 : code;
  endfunction

  function automatic logic [31:0] exp_send(input logic [31:0] old, input int n);
    logic [63:0] w = {32'd0, old};
    return 32'(w >> n);
  endfunction

  function automatic logic [31:0] exp_recv(input logic [31:0] old, input logic [31:0] v, input int n);
    logic [63:0] keep = {32'd0, old} >> n;
    logic [63:0] fld  = {32'd0, v} & ((64'd1 << n) - 64'd1);
    return 32'(keep | (fld << (32 - n)));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic mv_write(input int r, input logic [31:0] v);
    @(negedge clk);
    mv_we = 1'b1; mv_addr = 5'(r); mv_wdata = v;
    @(negedge clk);
    mv_we = 1'b0;
    shadow[r] = v;
  endtask

  task automatic mv_read(input int r, output logic [31:0] v);
    @(negedge clk);
    mv_addr = 5'(r);
    @(negedge clk);
    v = mv_rdata;
  endtask

  task automatic run_xfer(input bit is_out, input int r, input int p, input int wc,
                          input int stall_pct, input logic [31:0] rxv, input bit poke);
    int n = width_of(wc);
    logic [31:0] old = shadow[r];
    logic [31:0] exp_v, got = '0, v;
    int cyc = 0, beats = 0, stalls = 0, dones = 0;
    bit seen = 0, prev_stall = 0, prev_bit = 0;
    int other = (r + 1) % 32;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_is_out = is_out; cmd_reg = 5'(r);
    cmd_port = 8'(p); cmd_width = 5'(wc); mv_addr = 5'(r);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, "R2 busy after accept", 32'(busy), 32'd1);
    while (!seen && cyc < 400) begin
      if (poke && cyc == 2) begin
        cmd_valid = 1'b1; cmd_is_out = ~is_out; cmd_reg = 5'(other); cmd_width = 5'd3;
      end else begin
        cmd_valid = 1'b0;
      end
      chk(mv_rdata == old, "R9 read during transfer", mv_rdata, old);
      if (done) begin
        seen = 1;
        chk(cyc == 7 + n + stalls, "R7 done latency", 32'(cyc), 32'(7 + n + stalls));
        chk(busy == 1'b0, "R7 busy low at done", 32'(busy), 32'd0);
        chk(beats == n, "R3 beat count", 32'(beats), 32'(n));
      end else begin
        if (prev_stall) begin
          chk(tx_valid == 1'b1 && tx_data == prev_bit, "R8 hold while stalled",
              32'(tx_data), 32'(prev_bit));
        end
        prev_stall = 0;
        tx_ready = 1'b0; rx_valid = 1'b0;
        if (tx_valid) begin
          chk(is_out && port_sel == 8'(p) && !rx_ready, "R4 send port select",
              32'(port_sel), 32'(p));
          if (32'($urandom_range(99)) < 32'(stall_pct)) begin
            stalls++; prev_stall = 1; prev_bit = tx_data;
          end else begin
            tx_ready = 1'b1;
            if (beats < 32) got[beats] = tx_data;
            beats++;
          end
        end
        if (rx_ready) begin
          chk(!is_out && port_sel == 8'(p), "R6 receive port select", 32'(port_sel), 32'(p));
          if (32'($urandom_range(99)) < 32'(stall_pct)) begin
            stalls++;
          end else begin
            rx_valid = 1'b1;
            rx_data = (beats < 32) ? rxv[beats] : 1'b0;
            beats++;
          end
        end
        @(negedge clk);
        if (done) dones++;
        cyc++;
      end
    end
    tx_ready = 1'b0; rx_valid = 1'b0; cmd_valid = 1'b0;
    chk(seen, "R7 done seen", 32'(seen), 32'd1);
    exp_v = is_out ? exp_send(old, n) : exp_recv(old, rxv, n);
    if (is_out)
      chk(exp_send({got[31:0]}, 0) == (old & 32'((64'd1 << n) - 64'd1)) || n == 32 && got == old,
          "R4 sent bits LSB first", got, old);
    @(negedge clk);
    chk(done == 1'b0, "R7 done single cycle", 32'(done), 32'd0);
    chk(mv_rdata == exp_v, is_out ? "R5 send write-back" : "R6 receive write-back",
        mv_rdata, exp_v);
    shadow[r] = exp_v;
    if (poke) begin
      dones = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (done) dones++;
      end
      chk(dones == 0 && busy == 1'b0, "R2 command ignored while busy (no done)",
          32'(dones), 32'd0);
      mv_read(other, v);
      chk(v == shadow[other], "R2 command ignored while busy (register)", v, shadow[other]);
    end
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0, "R1 reset busy/done", {busy, done}, 0);
    chk(tx_valid == 0 && rx_ready == 0, "R1 reset port outputs", {tx_valid, rx_ready}, 0);
    mv_read(5, v);
    chk(v == 32'd0, "R1 reset register value", v, 0);

    mv_write(9, 32'hA5A5_0F0F);
    mv_read(9, v);
    chk(v == 32'hA5A5_0F0F, "R9 move write then read", v, 32'hA5A5_0F0F);

    mv_write(3, 32'hDEAD_BEEF);
    run_xfer(1, 3, 8'h5A, 0, 0, '0, 0);          // R3 width code 0 send
    mv_write(4, 32'h8000_0003);
    run_xfer(1, 4, 8'h01, 1, 0, '0, 0);          // R5 single-bit send
    mv_write(7, 32'hFFFF_FFFF);
    run_xfer(0, 7, 8'hFF, 0, 0, 32'h1234_5678, 0); // R6 full-width receive
    mv_write(8, 32'h0000_0000);
    run_xfer(0, 8, 8'h10, 1, 0, 32'h1, 0);       // R6 single-bit receive
    mv_write(10, 32'hCAFE_F00D);
    run_xfer(0, 10, 8'h33, 31, 40, 32'h5555_AAAA, 0);
    mv_write(11, 32'h7654_3210);
    run_xfer(1, 11, 8'hC3, 31, 50, '0, 1);       // R8 stalls, R2 poke

    for (int t = 0; t < 40; t++) begin
      int r = $urandom_range(31);
      if ($urandom_range(1) == 1) mv_write(r, $urandom);
      run_xfer(1'($urandom_range(1)), r, $urandom_range(255), $urandom_range(31),
               $urandom_range(60), $urandom, (t % 10) == 5);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule